// File: doc/BRIEF.md
# Function-Coded Arithmetic and Logic Unit

This block is a purely combinational 32-bit arithmetic and logic unit. It takes two operands and a 6-bit function code, and it returns one 32-bit result. The top two bits of the code choose a result group: comparison, add/subtract, bitwise Boolean or shift. The low four bits are passed to the chosen unit as its own sub-code.

A small decoder turns the function code into a bundle of select and mode strobes. The datapath then steers its operands through a shared adder/subtractor, a per-bit truth-table unit and a logarithmic shifter, and picks one result. Comparisons have no comparator of their own. They always run the subtractor and build the answer from its zero, sign and overflow flags, so signed ordering costs only a few gates.

Top module: `fn_alu`

## Requirements
- R1: `fn[5:4]` selects the result group. 00 is comparison, 01 is add/subtract, 10 is Boolean and 11 is shift. With the same `fn[3:0]`, the four groups give their four different results.
- R2: In group 01, `fn[0]=0` gives `y = a + b` and `fn[0]=1` gives `y = a - b`, both modulo 2^32. `fn[3:1]` has no effect.
- R3: Comparison codes with `fn[2:1]=01` give `y = 1` when `a == b` and 0 otherwise.
- R4: Comparison codes with `fn[2:1]=10` give `y = 1` when `a < b` as signed two's-complement values, and 0 otherwise.
- R5: Comparison codes with `fn[2:1]=11` give `y = 1` when `a <= b` signed, and 0 otherwise. In the comparison group, `fn[3]` and `fn[0]` have no effect.
- R6: A comparison result always has bits 31 to 1 at zero. A comparison code with `fn[2:1]=00` gives `y = 0`.
- R7: In group 10, each bit is `y[i] = fn[2*b[i] + a[i]]`. So `fn[0]` applies when both operand bits are 0 and `fn[3]` applies when both are 1.
- R8: Shift code `fn[1:0]=00` gives `y = a << b[4:0]`, with zeros filled in.
- R9: Shift code `fn[1:0]=01` gives a logical right shift of `a` by `b[4:0]`, with zeros filled in.
- R10: Shift code `fn[1:0]=11` gives an arithmetic right shift of `a` by `b[4:0]`, with copies of `a[31]` filled in.
- R11: During shifts, `b[31:5]` has no effect on `y`.
- R12: Shift code `fn[1:0]=10` gives `y = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 32 | First operand; the value that is shifted |
| b | input | 32 | Second operand; its low 5 bits are the shift amount |
| fn | input | 6 | Function code: group in bits 5:4, sub-code in bits 3:0 |
| y | output | 32 | Result |

## Verification
All results are combinational, so each result is due in the same cycle its inputs are applied, with no register between the ports. The bench drives new operands and a new code on the falling clock edge. It samples `y` one nanosecond later, well before the next edge, so each check sees only its own stimulus after the logic has settled. It sweeps all 64 function codes over every pair drawn from a set of edge-case operands, and adds targeted passes for group selection and for the ignored upper shift bits.

// File: rtl/fn_alu_pkg.sv
package fn_alu_pkg;

  typedef enum logic [1:0] {
    GRP_CMP   = 2'b00,
    GRP_ARITH = 2'b01,
    GRP_BOOL  = 2'b10,
    GRP_SHIFT = 2'b11
  } grp_e;

  typedef struct packed {
    logic       selCmp;
    logic       selArith;
    logic       selBool;
    logic       selShift;
    logic       doSub;
    logic       cmpEq;
    logic       cmpLt;
    logic       shLeft;
    logic       shArith;
    logic       shKill;
    logic [3:0] boolCode;
  } aluCtl_t;

endpackage

// File: rtl/fn_alu_ctrl.sv
module fn_alu_ctrl
  import fn_alu_pkg::*;
(
  input  logic [5:0] fn,
  output aluCtl_t    ctl
);

  grp_e grp;

  always_comb begin
    grp = grp_e'(fn[5:4]);
    ctl = '0;
    ctl.boolCode = fn[3:0];
    unique case (grp)
      GRP_CMP: begin
        ctl.selCmp = 1'b1;
        ctl.cmpEq  = fn[1];
        ctl.cmpLt  = fn[2];
      end
      GRP_ARITH: ctl.selArith = 1'b1;
      GRP_BOOL:  ctl.selBool  = 1'b1;
      GRP_SHIFT: begin
        ctl.selShift = 1'b1;
        ctl.shLeft   = (fn[1:0] == 2'b00);
        ctl.shArith  = fn[1];
        ctl.shKill   = (fn[1:0] == 2'b10);
      end
      default: ;
    endcase
    // comparisons always subtract; arithmetic subtracts on fn[0]
    ctl.doSub = (grp == GRP_CMP) | ((grp == GRP_ARITH) & fn[0]);
  end

endmodule

// File: rtl/fn_alu_shifter.sv
module fn_alu_shifter #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SHW-1:0]   shamt,
  input  logic             left,
  input  logic             arith,
  input  logic             kill,
  output logic [WIDTH-1:0] dout
);

  function automatic logic [WIDTH-1:0] bitRev(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
    return r;
  endfunction

  logic             fillBit;
  logic [WIDTH-1:0] stg [SHW+1];

  assign fillBit = arith & ~left & din[WIDTH-1];
  assign stg[0]  = left ? bitRev(din) : din;

  // one right-shift stage per shift-amount bit
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 2 ** k;
    assign stg[k+1] = shamt[k] ? {{STEP{fillBit}}, stg[k][WIDTH-1:STEP]} : stg[k];
  end

  assign dout = kill ? '0 : (left ? bitRev(stg[SHW]) : stg[SHW]);

  always_comb begin
    if (shamt == '0 && !kill)
      p_zero_amount_passthru_r8: assert (dout == din);
    if (arith && !left && !kill)
      p_sign_kept_r10: assert (dout[WIDTH-1] == din[WIDTH-1]);
  end

endmodule

// File: rtl/fn_alu_datapath.sv
module fn_alu_datapath
  import fn_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  aluCtl_t          ctl,
  output logic [WIDTH-1:0] y
);

  logic [WIDTH-1:0] bOp, sum, boolRes, shRes, cmpRes;
  logic             zFlag, nFlag, vFlag, cmpBit;

  // shared adder/subtractor
  assign bOp = ctl.doSub ? ~b : b;
  assign sum = a + bOp + {{(WIDTH-1){1'b0}}, ctl.doSub};

  // flags of the difference
  assign zFlag = (sum == '0);
  assign nFlag = sum[WIDTH-1];
  assign vFlag = (a[WIDTH-1] ^ b[WIDTH-1]) & (sum[WIDTH-1] ^ a[WIDTH-1]);

  assign cmpBit = (ctl.cmpEq & zFlag) | (ctl.cmpLt & (nFlag ^ vFlag));
  assign cmpRes = {{(WIDTH-1){1'b0}}, cmpBit};

  // per-bit truth-table lookup
  for (genvar i = 0; i < WIDTH; i++) begin : g_bool
    assign boolRes[i] = ctl.boolCode[{b[i], a[i]}];
  end

  fn_alu_shifter #(.WIDTH(WIDTH)) u_shifter (
    .din   (a),
    .shamt (b[SHW-1:0]),
    .left  (ctl.shLeft),
    .arith (ctl.shArith),
    .kill  (ctl.shKill),
    .dout  (shRes)
  );

  always_comb begin
    y = '0;
    unique case (1'b1)
      ctl.selCmp:   y = cmpRes;
      ctl.selArith: y = sum;
      ctl.selBool:  y = boolRes;
      ctl.selShift: y = shRes;
      default:      y = '0;
    endcase
  end

  always_comb begin
    p_one_group_r1: assert ($countones({ctl.selCmp, ctl.selArith,
                                        ctl.selBool, ctl.selShift}) == 1);
    if (ctl.selCmp) begin
      p_cmp_subtracts_r4: assert (ctl.doSub);
      p_cmp_upper_zero_r6: assert (y[WIDTH-1:1] == '0);
    end
    if (ctl.doSub)
      p_zero_flag_r3: assert (zFlag == (a == b));
  end

endmodule

// File: rtl/fn_alu.sv
module fn_alu
  import fn_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [5:0]       fn,
  output logic [WIDTH-1:0] y
);

  aluCtl_t ctl;

  fn_alu_ctrl u_ctrl (
    .fn  (fn),
    .ctl (ctl)
  );

  fn_alu_datapath #(.WIDTH(WIDTH)) u_datapath (
    .a   (a),
    .b   (b),
    .ctl (ctl),
    .y   (y)
  );

endmodule

// File: tb/fn_alu_bench.sv
module fn_alu_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [5:0]  fn = '0;
  logic [31:0] y;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  fn_alu u_fn_alu (.a(a), .b(b), .fn(fn), .y(y));

  function automatic logic [31:0] pat(input int idx);
    case (idx)
      0:  return 32'h0000_0000;
      1:  return 32'h0000_0001;
      2:  return 32'hFFFF_FFFF;
      3:  return 32'h8000_0000;
      4:  return 32'h7FFF_FFFF;
      5:  return 32'hAAAA_5555;
      6:  return 32'h5555_AAAA;
      7:  return 32'h0000_001F;
      8:  return 32'h0000_0020;
      9:  return 32'hFFFF_FFE3;
      10: return 32'h8000_0001;
      11: return 32'h1234_5678;
      12: return 32'hFEDC_BA98;
      13: return 32'h0000_0010;
      14: return 32'hFFFF_FFFE;
      default: return 32'h0F0F_00F0;
    endcase
  endfunction

  // reference model written from the requirements
  function automatic logic [31:0] model(input logic [5:0] f, input logic [31:0] x,
                                        input logic [31:0] z, output string req);
    logic [31:0] r;
    logic [4:0]  sh;
    r  = '0;
    sh = z[4:0];
    req = "";
    case (f[5:4])
      2'b00: begin
        case (f[2:1])
          2'b00: req = "R6";
          2'b01: req = "R3";
          2'b10: req = "R4";
          default: req = "R5";
        endcase
        r[0] = (f[1] && x == z) || (f[2] && ($signed(x) < $signed(z)));
      end
      2'b01: begin
        req = "R2";
        r = f[0] ? x - z : x + z;
      end
      2'b10: begin
        req = "R7";
        for (int i = 0; i < 32; i++) r[i] = f[2*z[i] + x[i]];
      end
      default: begin
        case (f[1:0])
          2'b00: begin req = "R8";  r = x << sh; end
          2'b01: begin req = "R9";  r = x >> sh; end
          2'b11: begin req = "R10"; r = $unsigned($signed(x) >>> sh); end
          default: begin req = "R12"; r = '0; end
        endcase
      end
    endcase
    return r;
  endfunction

  task automatic applyCheck(input logic [5:0] f, input logic [31:0] x,
                            input logic [31:0] z, input string tagOverride);
    string       req;
    logic [31:0] exp;
    @(negedge clk);
    fn = f; a = x; b = z;
    #1;
    exp = model(f, x, z, req);
    if (tagOverride != "") req = tagOverride;
    checks++;
    if (y !== exp) begin
      failures++;
      $display("FAIL %s fn=%b a=%h b=%h actual=%h expected=%h", req, f, x, z, y, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // all-zero inputs: comparison group code 0 gives zero (R6)
    applyCheck(6'b000000, 32'h0, 32'h0, "R6");

    // R1: same low bits, four groups, four distinct results
    for (int g = 0; g < 4; g++)
      applyCheck({g[1:0], 4'b0011}, 32'h0000_00F3, 32'h0000_0002, "R1");

    // sweep every code over all operand pairs (R2..R10, R12)
    for (int f = 0; f < 64; f++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          applyCheck(f[5:0], pat(i), pat(j), "");

    // R11: upper bits of b vary, shift amount fixed
    for (int s = 0; s < 4; s++)
      for (int amt = 0; amt < 32; amt++)
        for (int up = 0; up < 3; up++)
          applyCheck({4'b1100, s[1:0]}, pat(amt % 16),
                     {(up == 0) ? 27'h0 : (up == 1) ? 27'h7FF_FFFF : 27'h2A5_5A5A, amt[4:0]},
                     "R11");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule